// File: doc/BRIEF.md
# Bit-Parallel Edit Distance Dictionary Search

This block finds the dictionary word closest to a search word, measured as Levenshtein edit distance. Software first places a table of per-character match vectors and a list of zero-terminated dictionary words in external memory. It then programs the search word length and sets a start bit. The engine walks the dictionary one byte per step. It fetches each character, then the match vector for that character, and advances a bit-parallel edit distance recurrence that keeps one column of the distance matrix in two 16-bit delta vectors.

When a word's terminator is reached, the engine compares that word's distance with the best seen so far and keeps the smaller one. An empty word marks the end of the dictionary. At that point the engine clears its busy flag and leaves the best word index and its distance readable. Memory traffic goes through a byte-wide Wishbone Classic master port. Control and results go through a byte-wide Wishbone Classic slave port.

Top module: `edsearch_top`

## Requirements
- R1: After reset, a read of the control register shows busy (bit 0) at 0, the length register reads 0, both index bytes read 0 and the distance register reads 0xFF.
- R2: The slave registers are byte-wide at these offsets: 0 control (write bit 0 = 1 starts a scan, read bit 0 = busy), 1 length minus one, 2 best index high byte, 3 best index low byte, 4 best distance. Each access is acknowledged with a single-cycle ack.
- R3: For a character code c, the 16-bit match vector is read from map base 0x000200 + 2*c, most significant byte at the lower address. Bit i is set when search word position i equals c.
- R4: Dictionary words start at 0x000400 and lie back to back. Each word ends with a 0x00 byte, and a 0x00 byte in the first position of a word ends the dictionary.
- R5: The distance reported for a word equals the Levenshtein distance between that word and the search word, for search word lengths from 1 to 16.
- R6: The reported word is the one with the smallest distance. On a tie the earlier word is kept. The index counts words from 0 and is returned as a 16-bit value, high byte at offset 2.
- R7: An empty dictionary leaves the index at 0 and the distance at 0xFF.
- R8: Busy reads 1 from the cycle after a start write until the results are final. While busy, writes to the start bit and to the length register have no effect.
- R9: The master port only reads. Strobe is never active without cycle. The address is held from strobe until ack. Every address issued lies in the map region or the dictionary region.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wbs_cyc_i | input | 1 | Slave bus cycle |
| wbs_stb_i | input | 1 | Slave strobe |
| wbs_we_i | input | 1 | Slave write enable |
| wbs_adr_i | input | 3 | Slave register offset |
| wbs_dat_i | input | 8 | Slave write data |
| wbs_dat_o | output | 8 | Slave read data |
| wbs_ack_o | output | 1 | Slave acknowledge |
| wbm_cyc_o | output | 1 | Master bus cycle |
| wbm_stb_o | output | 1 | Master strobe |
| wbm_we_o | output | 1 | Master write enable, always 0 |
| wbm_adr_o | output | 24 | Master byte address |
| wbm_dat_i | input | 8 | Master read data |
| wbm_ack_i | input | 1 | Master acknowledge |

## Verification
Each dictionary is scored by a plain dynamic-programming distance computed in the bench. A recurrence that shifted in zero instead of one at the top row would score substrings and report 0 for a word that only contains the pattern. The bench targets these cases: ties between equal distances (a non-strict compare would report the later word), a 16-character pattern (a wrong last-bit index would miscount the score), a best word past index 255 (a byte-swapped index would show up) and an empty dictionary (the 0xFF sentinel must survive). It also writes the start bit and the length register while a scan runs, then reads the length back. A monitor on every clock checks that master addresses stay inside the two memory regions.

// File: rtl/edsearch_pkg.sv
package edsearch_pkg;
  localparam int IDX_W  = 16;
  localparam int DIST_W = 8;
  localparam int RA_W   = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_CHAR, ST_VEC, ST_STEP} seq_state_e;

  localparam logic [RA_W-1:0] REG_CTRL   = 3'd0;
  localparam logic [RA_W-1:0] REG_LEN    = 3'd1;
  localparam logic [RA_W-1:0] REG_IDX_HI = 3'd2;
  localparam logic [RA_W-1:0] REG_IDX_LO = 3'd3;
  localparam logic [RA_W-1:0] REG_DIST   = 3'd4;
endpackage

// File: rtl/edsearch_core.sv
module edsearch_core #(
  parameter int VEC_W  = 16,
  parameter int DIST_W = 8,
  localparam int LAST_W = $clog2(VEC_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              step_i,
  input  logic [VEC_W-1:0]  eq_i,
  input  logic [LAST_W-1:0] last_i,
  output logic [DIST_W-1:0] score_o
);
  logic [VEC_W-1:0] pv_q, mv_q;
  logic [VEC_W-1:0] xv, xh, ph, mh, ph_s, mh_s, pv_n, mv_n;
  logic [DIST_W-1:0] score_q, score_n;

  always_comb begin
    xv   = eq_i | mv_q;
    xh   = (((eq_i & pv_q) + pv_q) ^ pv_q) | eq_i;
    ph   = mv_q | ~(xh | pv_q);
    mh   = pv_q & xh;
    // top boundary row grows by one per text char: shift in 1
    ph_s = {ph[VEC_W-2:0], 1'b1};
    mh_s = {mh[VEC_W-2:0], 1'b0};
    pv_n = mh_s | ~(xv | ph_s);
    mv_n = ph_s & xv;
    score_n = score_q;
    if (ph[last_i] && score_q != '1)      score_n = score_q + DIST_W'(1);
    else if (mh[last_i] && score_q != '0) score_n = score_q - DIST_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pv_q    <= '1;
      mv_q    <= '0;
      score_q <= '0;
    end else if (init_i) begin
      pv_q    <= '1;
      mv_q    <= '0;
      score_q <= DIST_W'(last_i) + DIST_W'(1);
    end else if (step_i) begin
      pv_q    <= pv_n;
      mv_q    <= mv_n;
      score_q <= score_n;
    end
  end

  assign score_o = score_q;

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && mh[last_i] |-> score_q != '0); // R5
endmodule

// File: rtl/edsearch_regs.sv
module edsearch_regs
  import edsearch_pkg::*;
#(
  parameter int LAST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [RA_W-1:0]   adr_i,
  input  logic [7:0]        dat_i,
  output logic [7:0]        dat_o,
  output logic              ack_o,
  input  logic              busy_i,
  input  logic [IDX_W-1:0]  best_idx_i,
  input  logic [DIST_W-1:0] best_dist_i,
  output logic              start_o,
  output logic [LAST_W-1:0] last_o
);
  logic       ack_q;
  logic [7:0] dat_q, len_q, rd_val;
  logic       req;

  assign req = cyc_i && stb_i && !ack_q;

  always_comb begin
    case (adr_i)
      REG_CTRL:   rd_val = {7'd0, busy_i};
      REG_LEN:    rd_val = len_q;
      REG_IDX_HI: rd_val = best_idx_i[15:8];
      REG_IDX_LO: rd_val = best_idx_i[7:0];
      REG_DIST:   rd_val = best_dist_i;
      default:    rd_val = 8'd0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      dat_q   <= '0;
      len_q   <= '0;
      start_o <= 1'b0;
    end else begin
      ack_q   <= req;
      start_o <= 1'b0;
      if (req) dat_q <= rd_val;
      if (req && we_i && !busy_i) begin
        if (adr_i == REG_LEN) len_q <= dat_i;
        if (adr_i == REG_CTRL && dat_i[0]) start_o <= 1'b1;
      end
    end
  end

  assign ack_o  = ack_q;
  assign dat_o  = dat_q;
  assign last_o = len_q[LAST_W-1:0];

  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R2
endmodule

// File: rtl/edsearch_seq.sv
module edsearch_seq
  import edsearch_pkg::*;
#(
  parameter int          VEC_W     = 16,
  parameter int          ADR_W     = 24,
  parameter logic [23:0] MAP_BASE  = 24'h000200,
  parameter logic [23:0] DICT_BASE = 24'h000400,
  localparam int VEC_BYTES = VEC_W / 8,
  localparam int CNT_W     = (VEC_BYTES > 1) ? $clog2(VEC_BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              m_cyc_o,
  output logic              m_stb_o,
  output logic [ADR_W-1:0]  m_adr_o,
  input  logic [7:0]        m_dat_i,
  input  logic              m_ack_i,
  output logic              core_init_o,
  output logic              core_step_o,
  output logic [VEC_W-1:0]  eq_o,
  input  logic [DIST_W-1:0] score_i,
  output logic              busy_o,
  output logic [IDX_W-1:0]  best_idx_o,
  output logic [DIST_W-1:0] best_dist_o
);
  seq_state_e        state_q;
  logic [ADR_W-1:0]  adr_q;
  logic [7:0]        ch_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [VEC_W-1:0]  eq_q;
  logic [IDX_W-1:0]  word_q, best_idx_q;
  logic [DIST_W-1:0] best_dist_q;
  logic              first_q;
  logic              word_end, dict_end;

  assign m_cyc_o = (state_q == ST_CHAR) || (state_q == ST_VEC);
  assign m_stb_o = m_cyc_o;
  assign m_adr_o = (state_q == ST_VEC)
                 ? ADR_W'(MAP_BASE) + ADR_W'(ch_q) * ADR_W'(VEC_BYTES) + ADR_W'(cnt_q)
                 : adr_q;

  assign word_end = (state_q == ST_CHAR) && m_ack_i && (m_dat_i == 8'd0) && !first_q;
  assign dict_end = (state_q == ST_CHAR) && m_ack_i && (m_dat_i == 8'd0) && first_q;

  assign core_init_o = ((state_q == ST_IDLE) && start_i) || word_end;
  assign core_step_o = (state_q == ST_STEP);
  assign eq_o        = eq_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign best_idx_o  = best_idx_q;
  assign best_dist_o = best_dist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      adr_q       <= '0;
      ch_q        <= '0;
      cnt_q       <= '0;
      eq_q        <= '0;
      word_q      <= '0;
      best_idx_q  <= '0;
      best_dist_q <= '1;
      first_q     <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          adr_q       <= ADR_W'(DICT_BASE);
          word_q      <= '0;
          best_idx_q  <= '0;
          best_dist_q <= '1;
          first_q     <= 1'b1;
          state_q     <= ST_CHAR;
        end
        ST_CHAR: if (m_ack_i) begin
          adr_q <= adr_q + ADR_W'(1);
          if (dict_end) begin
            state_q <= ST_IDLE;
          end else if (word_end) begin
            // strict compare keeps the earlier word on a tie
            if (score_i < best_dist_q) begin
              best_dist_q <= score_i;
              best_idx_q  <= word_q;
            end
            word_q  <= word_q + IDX_W'(1);
            first_q <= 1'b1;
          end else begin
            ch_q    <= m_dat_i;
            cnt_q   <= '0;
            first_q <= 1'b0;
            state_q <= ST_VEC;
          end
        end
        ST_VEC: if (m_ack_i) begin
          eq_q  <= {eq_q[VEC_W-9:0], m_dat_i};
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(VEC_BYTES - 1)) state_q <= ST_STEP;
        end
        default: state_q <= ST_CHAR;
      endcase
    end
  end

  AST_STB_IN_CYC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_stb_o |-> m_cyc_o); // R9
  AST_ADR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_stb_o && !m_ack_i |=> m_stb_o && $stable(m_adr_o)); // R9
  AST_MASTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_cyc_o |-> busy_o); // R8
  AST_BEST_NONINC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> best_dist_o <= $past(best_dist_o)); // R6
endmodule

// File: rtl/edsearch_top.sv
module edsearch_top
  import edsearch_pkg::*;
#(
  parameter int          VEC_W     = 16,
  parameter int          ADR_W     = 24,
  parameter logic [23:0] MAP_BASE  = 24'h000200,
  parameter logic [23:0] DICT_BASE = 24'h000400
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wbs_cyc_i,
  input  logic             wbs_stb_i,
  input  logic             wbs_we_i,
  input  logic [2:0]       wbs_adr_i,
  input  logic [7:0]       wbs_dat_i,
  output logic [7:0]       wbs_dat_o,
  output logic             wbs_ack_o,
  output logic             wbm_cyc_o,
  output logic             wbm_stb_o,
  output logic             wbm_we_o,
  output logic [ADR_W-1:0] wbm_adr_o,
  input  logic [7:0]       wbm_dat_i,
  input  logic             wbm_ack_i
);
  localparam int LAST_W = $clog2(VEC_W);

  logic              start, busy, core_init, core_step;
  logic [LAST_W-1:0] last;
  logic [VEC_W-1:0]  eq;
  logic [DIST_W-1:0] score, best_dist;
  logic [IDX_W-1:0]  best_idx;

  assign wbm_we_o = 1'b0;

  edsearch_regs #(.LAST_W(LAST_W)) u_regs (
    .clk_i, .rst_ni,
    .cyc_i(wbs_cyc_i), .stb_i(wbs_stb_i), .we_i(wbs_we_i), .adr_i(wbs_adr_i),
    .dat_i(wbs_dat_i), .dat_o(wbs_dat_o), .ack_o(wbs_ack_o),
    .busy_i(busy), .best_idx_i(best_idx), .best_dist_i(best_dist),
    .start_o(start), .last_o(last)
  );

  edsearch_seq #(
    .VEC_W(VEC_W), .ADR_W(ADR_W), .MAP_BASE(MAP_BASE), .DICT_BASE(DICT_BASE)
  ) u_seq (
    .clk_i, .rst_ni, .start_i(start),
    .m_cyc_o(wbm_cyc_o), .m_stb_o(wbm_stb_o), .m_adr_o(wbm_adr_o),
    .m_dat_i(wbm_dat_i), .m_ack_i(wbm_ack_i),
    .core_init_o(core_init), .core_step_o(core_step), .eq_o(eq), .score_i(score),
    .busy_o(busy), .best_idx_o(best_idx), .best_dist_o(best_dist)
  );

  edsearch_core #(.VEC_W(VEC_W), .DIST_W(DIST_W)) u_core (
    .clk_i, .rst_ni, .init_i(core_init), .step_i(core_step),
    .eq_i(eq), .last_i(last), .score_o(score)
  );
endmodule

// File: tb/edsearch_tb.sv
`timescale 1ns/1ps
module edsearch_top_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic s_cyc = 0, s_stb = 0, s_we = 0;
  logic [2:0] s_adr = 0;
  logic [7:0] s_wdat = 0, s_rdat;
  logic s_ack;
  logic m_cyc, m_stb, m_we, m_ack;
  logic [23:0] m_adr;
  logic [7:0] m_dat;

  logic [7:0] mem [0:8191];
  int n_chk = 0, n_fail = 0, mon_err = 0;
  int dict_end_adr = 24'h400;

  edsearch_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wbs_cyc_i(s_cyc), .wbs_stb_i(s_stb), .wbs_we_i(s_we), .wbs_adr_i(s_adr),
    .wbs_dat_i(s_wdat), .wbs_dat_o(s_rdat), .wbs_ack_o(s_ack),
    .wbm_cyc_o(m_cyc), .wbm_stb_o(m_stb), .wbm_we_o(m_we), .wbm_adr_o(m_adr),
    .wbm_dat_i(m_dat), .wbm_ack_i(m_ack)
  );

  // memory model: registered single-cycle ack
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ack <= 1'b0;
      m_dat <= 8'd0;
    end else begin
      m_ack <= m_cyc && m_stb && !m_ack;
      m_dat <= mem[m_adr[12:0]];
    end
  end

  // R9 per-clock bus monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_stb && !m_cyc) mon_err++;
      if (m_cyc && m_we) mon_err++;
      if (m_cyc && !((m_adr >= 24'h200 && m_adr < 24'h400) ||
                     (m_adr >= 24'h400 && int'(m_adr) <= dict_end_adr))) mon_err++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wb_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    s_cyc = 1; s_stb = 1; s_we = 1; s_adr = a; s_wdat = d;
    do @(negedge clk); while (!s_ack);
    s_cyc = 0; s_stb = 0; s_we = 0;
  endtask

  task automatic wb_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    s_cyc = 1; s_stb = 1; s_we = 0; s_adr = a;
    do @(negedge clk); while (!s_ack);
    d = s_rdat;
    s_cyc = 0; s_stb = 0;
  endtask

  function automatic int lev(input string a, input string b);
    int d [0:40][0:40];
    for (int i = 0; i <= a.len(); i++) d[i][0] = i;
    for (int j = 0; j <= b.len(); j++) d[0][j] = j;
    for (int i = 1; i <= a.len(); i++)
      for (int j = 1; j <= b.len(); j++) begin
        int c = d[i-1][j-1] + ((a[i-1] == b[j-1]) ? 0 : 1);
        if (d[i-1][j] + 1 < c) c = d[i-1][j] + 1;
        if (d[i][j-1] + 1 < c) c = d[i][j-1] + 1;
        d[i][j] = c;
      end
    return d[a.len()][b.len()];
  endfunction

  // R3 map layout, R4 dictionary layout
  task automatic load(input string pat, input string words[$]);
    int adr = 24'h400;
    for (int c = 0; c < 256; c++) begin
      logic [15:0] v = 16'd0;
      for (int i = 0; i < pat.len(); i++) if (pat[i] == 8'(c)) v[i] = 1'b1;
      mem[24'h200 + 2*c]     = v[15:8];
      mem[24'h200 + 2*c + 1] = v[7:0];
    end
    foreach (words[k]) begin
      for (int i = 0; i < words[k].len(); i++) begin mem[adr] = words[k][i]; adr++; end
      mem[adr] = 8'd0; adr++;
    end
    mem[adr] = 8'd0;
    dict_end_adr = adr;
  endtask

  task automatic run_case(input string tag, input string pat, input string words[$],
                          input bit chk_busy, input bit poke);
    int exp_idx = 0, exp_dist = 255;
    logic [7:0] v, hi, lo, ds;
    int polls = 0;
    foreach (words[k]) begin
      int dd = lev(pat, words[k]);
      if (dd < exp_dist) begin exp_dist = dd; exp_idx = k; end
    end
    load(pat, words);
    wb_write(3'd1, 8'(pat.len() - 1));
    wb_write(3'd0, 8'd1);
    if (chk_busy) begin
      wb_read(3'd0, v);
      check(v[0] == 1'b1, {"R8 busy after start ", tag}, int'(v[0]), 1);
    end
    if (poke) begin
      wb_write(3'd1, 8'd7);
      wb_write(3'd0, 8'd1);
    end
    do begin wb_read(3'd0, v); polls++; end while (v[0] && polls < 20000);
    wb_read(3'd2, hi);
    wb_read(3'd3, lo);
    wb_read(3'd4, ds);
    check({hi, lo} == 16'(exp_idx), {"R6 index ", tag}, int'({hi, lo}), exp_idx);
    check(int'(ds) == exp_dist, {"R5 distance ", tag}, int'(ds), exp_dist);
    if (poke) begin
      wb_read(3'd1, v);
      check(int'(v) == pat.len() - 1, {"R8 length write ignored ", tag}, int'(v), pat.len() - 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL R8 watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    string w[$];
    for (int i = 0; i < 8192; i++) mem[i] = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    wb_read(3'd0, v); check(v == 8'd0, "R1 ctrl", int'(v), 0);
    wb_read(3'd1, v); check(v == 8'd0, "R1 length", int'(v), 0);
    wb_read(3'd2, v); check(v == 8'd0, "R1 index hi", int'(v), 0);
    wb_read(3'd3, v); check(v == 8'd0, "R1 index lo", int'(v), 0);
    wb_read(3'd4, v); check(v == 8'hFF, "R1 distance", int'(v), 255);

    w = '{"bat", "cart", "cat", "dog"};
    run_case("exact", "cat", w, 1, 0);
    // R6 tie keeps earlier; also start and length poked while busy (R8)
    w = '{"xb", "ay", "zzzz"};
    run_case("tie", "ab", w, 1, 1);
    w = '{"abc", "xyz", "qq"};
    run_case("len1", "q", w, 1, 0);
    // word containing the pattern must still score its extra chars (R5)
    w = '{"xxabcdefghijklmnopyy", "abcdefghijklmnoq", "bcdefghijklmnop"};
    run_case("len16", "abcdefghijklmnop", w, 1, 0);
    // R7 empty dictionary
    w = '{};
    run_case("empty", "cat", w, 0, 0);
    // R6 index above 255 exercises high byte
    w = '{};
    for (int i = 0; i < 300; i++) w.push_back("zz");
    w.push_back("cot");
    run_case("wide_index", "cat", w, 1, 0);

    check(mon_err == 0, "R9 master bus monitor", mon_err, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule